// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block is the clocked-logic end of a slow byte-wide bus that a microcontroller drives by toggling general-purpose pins in software. The address and the data share the same pins and are told apart only by three strobes: address latch, write and read. The byte does not sit on adjacent pins. Its low nibble is on physical pins 7:4 and its high nibble is on physical pins 19:16. All other pins in the 20-pin group belong to something else.

The strobes come from software and are asynchronous to the local clock. Each strobe passes through a two-flop synchroniser, and the block acts on the synchronised rising edge. On the latch edge it captures the address. On the write edge it captures the data and issues a single-cycle write to a register port. On the read edge it issues a single-cycle read pulse and takes the byte the register file returns. It drives that byte back onto the mapped pins, with the output enable raised only while the synchronised read strobe stays high.

Top module: `muxbus_slave`

## Requirements
- R1: After reset, reg_we, reg_re, reg_addr, reg_wdata and pin_oe are all zero.
- R2: On each rising edge of the synchronised latch strobe, reg_addr takes the byte whose bits 3:0 are pin_i[7:4] and whose bits 7:4 are pin_i[19:16].
- R3: Each rising edge of the synchronised write strobe yields one reg_we pulse, one cycle long. During that pulse reg_wdata holds the byte unmapped from the pins as in R2, and reg_addr is unchanged.
- R4: Each rising edge of the synchronised read strobe yields one reg_re pulse, one cycle long. The reg_rdata byte present in that cycle is then presented with bits 3:0 on pin_o[7:4] and bits 7:4 on pin_o[19:16].
- R5: pin_oe is nonzero only while the read strobe, delayed through the synchroniser, is high. It returns to zero no later than two clock edges after the read strobe falls.
- R6: Unmapped pins are ignored: pin_i values outside positions 7:4 and 19:16 never change a captured address or data byte. pin_oe and pin_o are always zero at those positions.
- R7: A strobe held high for many cycles produces exactly one pulse on the register port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 20 | Sampled value of the shared pin group |
| pin_o | output | 20 | Value driven onto the pin group during a read |
| pin_oe | output | 20 | Per-pin output enable, high only on mapped pins during a read |
| ale_i | input | 1 | Address latch strobe, asynchronous |
| wr_i | input | 1 | Write strobe, asynchronous |
| rd_i | input | 1 | Read strobe, asynchronous |
| reg_addr | output | 8 | Latched register address |
| reg_wdata | output | 8 | Write data for the register file |
| reg_we | output | 1 | One-cycle write enable |
| reg_re | output | 1 | One-cycle read pulse |
| reg_rdata | input | 8 | Read data returned by the register file for reg_addr |

## Verification
The in-module assertions check three things on every cycle: both port pulses last one cycle, the address stays put across a write pulse, and the output enable never rises unless the read strobe was high at the pin two and three edges earlier. Only the bench scenarios can show the rest: that the nibbles land at the right pin positions, that junk on unmapped pins is ignored, that a long strobe yields a single access, and that a read returns the byte written earlier.

// File: rtl/muxbus_slave.sv
module muxbus_slave #(
  parameter int PIN_W  = 20,
  parameter int LO_POS = 4,
  parameter int HI_POS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_i,
  output logic [PIN_W-1:0] pin_o,
  output logic [PIN_W-1:0] pin_oe,
  input  logic             ale_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [7:0]       reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  output logic             reg_re,
  input  logic [7:0]       reg_rdata
);

  localparam logic [PIN_W-1:0] MAP_MASK =
    (PIN_W'(4'hF) << LO_POS) | (PIN_W'(4'hF) << HI_POS);

  function automatic logic [7:0] unmap(input logic [PIN_W-1:0] p);
    return {p[HI_POS +: 4], p[LO_POS +: 4]};
  endfunction

  function automatic logic [PIN_W-1:0] remap(input logic [7:0] b);
    logic [PIN_W-1:0] p;
    p = '0;
    p[LO_POS +: 4] = b[3:0];
    p[HI_POS +: 4] = b[7:4];
    return p;
  endfunction

  logic [2:0] ale_s, wr_s, rd_s;
  logic [PIN_W-1:0] pin_q;
  logic [7:0] rd_q;

  wire ale_rise = ale_s[1] & ~ale_s[2];
  wire wr_rise  = wr_s[1]  & ~wr_s[2];
  wire rd_rise  = rd_s[1]  & ~rd_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_s     <= '0;
      wr_s      <= '0;
      rd_s      <= '0;
      pin_q     <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      rd_q      <= '0;
    end else begin
      ale_s  <= {ale_s[1:0], ale_i};
      wr_s   <= {wr_s[1:0], wr_i};
      rd_s   <= {rd_s[1:0], rd_i};
      pin_q  <= pin_i & MAP_MASK;
      reg_we <= wr_rise;
      if (ale_rise) reg_addr  <= unmap(pin_q);
      if (wr_rise)  reg_wdata <= unmap(pin_q);
      if (rd_rise)  rd_q      <= reg_rdata;
    end
  end

  assign reg_re = rd_rise;
  assign pin_o  = remap(rd_q);
  assign pin_oe = (rd_s[1] & rd_s[2]) ? MAP_MASK : '0;

  a_r3_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr));

  a_r4_re_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);

  a_r5_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_oe) |-> ($past(rd_i, 2) && $past(rd_i, 3)));

endmodule

// File: tb/muxbus_slave_tb.sv
module muxbus_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [19:0] MASK = 20'hF00F0;
  localparam logic [15:0] VEC [NV] = '{
    16'h00_5A, 16'hFF_A5, 16'h3C_00, 16'hC3_FF,
    16'h01_80, 16'h80_01, 16'h7E_96, 16'h42_24};

  logic clk = 0, rst_n = 0;
  logic [19:0] pin_i = '0, pin_o, pin_oe;
  logic ale_i = 0, wr_i = 0, rd_i = 0;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic reg_we, reg_re;
  logic [7:0] mem [256];
  int checks = 0, fails = 0, we_cnt = 0, re_cnt = 0;
  logic [7:0] last_wa, last_wd;

  always #(CLK_PERIOD/2) clk = ~clk;

  muxbus_slave u_dut (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe(pin_oe), .ale_i(ale_i), .wr_i(wr_i), .rd_i(rd_i),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      last_wa <= reg_addr; last_wd <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (reg_re) re_cnt <= re_cnt + 1;
  end

  function automatic logic [19:0] enc(input logic [7:0] b);
    return {b[7:4], 8'h00, b[3:0], 4'h0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d,
                           input logic [19:0] junk, input int hold);
    int w0;
    w0 = we_cnt;
    pin_i = enc(a) | (junk & ~MASK); ale_i = 1; cyc(5);
    ale_i = 0; pin_i = enc(d) | (~junk & ~MASK); wr_i = 1; cyc(hold);
    chk("R5 no drive during write", pin_oe, 0);
    wr_i = 0; pin_i = junk & ~MASK; cyc(4);
    chk("R3/R7 one write pulse", we_cnt - w0, 1);
    chk("R2/R6 write address", last_wa, a);
    chk("R3/R6 write data", last_wd, d);
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [7:0] exp,
                          input logic [19:0] junk, input int hold);
    int r0;
    r0 = re_cnt;
    pin_i = enc(a) | (junk & ~MASK); ale_i = 1; cyc(5);
    ale_i = 0; pin_i = junk & ~MASK; cyc(2);
    chk("R2 read address", reg_addr, a);
    rd_i = 1; cyc(hold);
    chk("R5/R6 oe mapped only", pin_oe, MASK);
    chk("R4 read byte on pins", pin_o & MASK, enc(exp));
    chk("R6 unmapped pins undriven", pin_o & ~MASK, 0);
    rd_i = 0; cyc(2);
    chk("R5 oe released", pin_oe, 0);
    cyc(2);
    chk("R4/R7 one read pulse", re_cnt - r0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h33);
    cyc(3);
    chk("R1 reg_we reset", reg_we, 0);
    chk("R1 reg_re reset", reg_re, 0);
    chk("R1 reg_addr reset", reg_addr, 0);
    chk("R1 reg_wdata reset", reg_wdata, 0);
    chk("R1 pin_oe reset", pin_oe, 0);
    rst_n = 1; cyc(2);

    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][15:8], VEC[i][7:0], 20'(32'hA5A5F ^ (i * 32'h1357)), 5);
      bus_read(VEC[i][15:8], VEC[i][7:0], 20'(32'h0F0F0 + i * 32'h2468), 5);
    end

    bus_write(8'h99, 8'h66, 20'hFFFFF, 40);
    bus_read(8'h99, 8'h66, 20'hFFFFF, 40);
    bus_read(8'h10, 8'h10 ^ 8'h33, 20'h0, 5);
    bus_read(8'h5A, 8'h5A ^ 8'h33, 20'h0FF0F, 30);

    cyc(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule